// File: doc/BRIEF.md
# Row hit address encoder with serial output

The block sits below a strip of column comparators. Each time the row source presents a row of binary hit flags for one group of columns, a balanced OR-reduction tree decides at once whether the row holds any hit. A row with no hit is dropped in the same clock cycle and the block stays free. A row with hits is latched, and a control state machine walks its columns in ascending order. For each set flag it pushes one word into a FIFO. The word holds the row number in its upper bits and the column index within the group in its lower bits.

A serialiser empties the FIFO onto a single output wire. Each word is sent as a frame made of one start bit at 1 and then the word bits, most significant bit first. Between frames the wire sits at 0. The block runs on one fast clock, which is the line clock. The scan advances only on processing ticks, one tick every `PROC_DIV` clocks, so the three rates keep a fixed integer ratio.

While a row is being encoded, `busy` tells the source to hold its next row. If the FIFO is full when a hit is due, that hit is dropped and a sticky overflow flag is raised. Words already stored are never overwritten.

Top module: `hitser_top`

## Requirements
- R1: After a synchronous reset, `ser_out`, `busy` and `overflow` are all 0.
- R2: A row presented with all hit flags at 0 writes nothing into the FIFO, and `busy` stays 0 in the following cycles.
- R3: When `busy` is 0, a row with at least one hit is captured at the clock edge where `row_valid` is 1, and `busy` is 1 from the next cycle until the scan ends.
- R4: A `row_valid` pulse while `busy` is 1 is ignored: it produces no words.
- R5: A captured row yields exactly one word per set flag, in ascending column order. Each word is `{row_num, column}`, with the row in the upper `ROW_W` bits and the column index (flag bit position) in the lower `COL_W` bits.
- R6: The wire is 0 when no frame is being sent. A frame is a 1 start bit followed by the `ROW_W+COL_W` word bits, most significant bit first, one bit per clock. A frame may follow the previous one with no gap.
- R7: The scan examines one column per processing tick (every `PROC_DIV` clocks). It returns to idle on the tick after the highest set column has been handled. For highest hit column c, `busy` therefore lasts between (c+1)·PROC_DIV+1 and (c+2)·PROC_DIV clocks.
- R8: A hit that finds the FIFO full is dropped and sets `overflow`. The flag stays 1 until reset, and stored words are kept.

Ports in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock; the scan uses a tick every PROC_DIV cycles |
| rst | input | 1 | Synchronous active-high reset |
| row_valid | input | 1 | A new row is offered this cycle |
| row_hits | input | COLS | Hit flags of the row, bit i is column i |
| row_num | input | ROW_W | Row number of the offered row |
| busy | output | 1 | A row is being encoded; hold new rows |
| ser_out | output | 1 | Serial frame output |
| overflow | output | 1 | Sticky: a hit was lost to a full FIFO |

## Verification
The bench builds the main instance with 8 columns, a 4-bit row number, a processing tick every 4 clocks and a 16-entry FIFO. With these values all 256 hit patterns can be swept, each with its decoded frames and its busy length checked against arithmetic. A second instance uses a tick on every clock and a 2-entry FIFO. A fully hit row therefore outruns the wire, which exercises the overflow drop and the sticky flag.

// File: rtl/hitser_pkg.sv
`timescale 1ns/1ps
package hitser_pkg;
  typedef enum logic {S_IDLE = 1'b0, S_SCAN = 1'b1} scan_state_t;

  function automatic int safe_clog2(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/hitser_ortree.sv
`timescale 1ns/1ps
module hitser_ortree #(
  parameter int N = 128
) (
  input  logic [N-1:0] flags,
  output logic         any
);
  localparam int LEVELS = (N > 1) ? $clog2(N) : 0;
  localparam int P      = 1 << LEVELS;

  logic [2*P-1:1] node;

  genvar i;
  generate
    for (i = 0; i < P; i++) begin : g_leaf
      if (i < N) begin : g_real
        assign node[P+i] = flags[i];
      end else begin : g_pad
        assign node[P+i] = 1'b0;
      end
    end
    for (i = 1; i < P; i++) begin : g_node
      assign node[i] = node[2*i] | node[2*i+1];
    end
  endgenerate

  assign any = node[1];
endmodule

// File: rtl/hitser_scan.sv
`timescale 1ns/1ps
module hitser_scan
  import hitser_pkg::*;
#(
  parameter int COLS  = 128,
  parameter int ROW_W = 7,
  parameter int COL_W = 7
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick,
  input  logic                   row_valid,
  input  logic [COLS-1:0]        row_hits,
  input  logic [ROW_W-1:0]       row_num,
  input  logic                   any,
  input  logic                   fifo_full,
  output logic [COLS-1:0]        tree_in,
  output logic                   busy,
  output logic                   wr_en,
  output logic [ROW_W+COL_W-1:0] wr_data,
  output logic                   overflow
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  scan_state_t       state_q;
  logic [COLS-1:0]   mask_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              ovf_q;
  logic              hit_here;

  assign busy     = (state_q == S_SCAN);
  assign tree_in  = busy ? mask_q : row_hits;
  assign hit_here = busy && tick && any && mask_q[col_q];
  assign wr_en    = hit_here && !fifo_full;
  assign wr_data  = {row_q, col_q};
  assign overflow = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      mask_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (hit_here && fifo_full) ovf_q <= 1'b1;
      case (state_q)
        S_IDLE: begin
          if (row_valid && any) begin
            mask_q  <= row_hits;
            row_q   <= row_num;
            col_q   <= '0;
            state_q <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (tick) begin
            if (!any) begin
              state_q <= S_IDLE;
            end else begin
              mask_q[col_q] <= 1'b0;
              if (col_q != LAST_COL) col_q <= col_q + 1'b1;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow); // R8
  AST_BUSY_FROM_ROW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(row_valid)); // R3
  AST_COL_ASCENDS: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (col_q >= $past(col_q))); // R5
endmodule

// File: rtl/hitser_fifo.sv
`timescale 1ns/1ps
module hitser_fifo #(
  parameter int WIDTH = 14,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int AW = hitser_pkg::safe_clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [AW:0]      cnt_q;
  logic             do_wr, do_rd;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_wr   = wr_en && !full;
  assign do_rd   = rd_en && !empty;
  assign rd_data = mem[rp_q];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_rd) rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      if (do_wr && !do_rd)      cnt_q <= cnt_q + 1'b1;
      else if (do_rd && !do_wr) cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= (AW+1)'(DEPTH)); // R8
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full); // R8
endmodule

// File: rtl/hitser_tx.sv
`timescale 1ns/1ps
module hitser_tx #(
  parameter int WW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          empty,
  input  logic [WW-1:0] word,
  output logic          pop,
  output logic          ser_out
);
  localparam int FW = WW + 1;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] sreg_q;
  logic [CW-1:0] cnt_q;

  assign pop     = (cnt_q <= CW'(1)) && !empty;
  assign ser_out = sreg_q[FW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (pop) begin
      sreg_q <= {1'b1, word};
      cnt_q  <= CW'(FW);
    end else if (cnt_q != '0) begin
      sreg_q <= {sreg_q[FW-2:0], 1'b0};
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  AST_LINE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0) |-> !ser_out); // R6
  AST_START_BIT: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CW'(FW)) |-> ser_out); // R6
endmodule

// File: rtl/hitser_top.sv
`timescale 1ns/1ps
module hitser_top #(
  parameter int COLS       = 128,
  parameter int ROW_W      = 7,
  parameter int FIFO_DEPTH = 16,
  parameter int PROC_DIV   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             row_valid,
  input  logic [COLS-1:0]  row_hits,
  input  logic [ROW_W-1:0] row_num,
  output logic             busy,
  output logic             ser_out,
  output logic             overflow
);
  localparam int COL_W = hitser_pkg::safe_clog2(COLS);
  localparam int WW    = ROW_W + COL_W;
  localparam int DIV_W = hitser_pkg::safe_clog2(PROC_DIV);

  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic [COLS-1:0]  tree_in;
  logic             any;
  logic             wr_en, rd_en, full, empty;
  logic [WW-1:0]    wr_data, rd_data;

  assign tick = (div_q == '0);

  always_ff @(posedge clk) begin
    if (rst || div_q == DIV_W'(PROC_DIV - 1)) div_q <= '0;
    else div_q <= div_q + 1'b1;
  end

  hitser_ortree #(.N(COLS)) u_tree (.flags(tree_in), .any(any));

  hitser_scan #(.COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) u_scan (
    .clk(clk), .rst(rst), .tick(tick), .row_valid(row_valid),
    .row_hits(row_hits), .row_num(row_num), .any(any), .fifo_full(full),
    .tree_in(tree_in), .busy(busy), .wr_en(wr_en), .wr_data(wr_data),
    .overflow(overflow));

  hitser_fifo #(.WIDTH(WW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty));

  hitser_tx #(.WW(WW)) u_tx (
    .clk(clk), .rst(rst), .empty(empty), .word(rd_data),
    .pop(rd_en), .ser_out(ser_out));

  AST_EMPTY_ROW_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && row_valid && row_hits == '0) |=> !busy); // R2
endmodule

// File: tb/hitser_top_bench.sv
`timescale 1ns/1ps
module hitser_top_bench;
  localparam int COLS = 8, ROW_W = 4, COL_W = 3, WW = 7, D = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic            a_valid = 1'b0, b_valid = 1'b0;
  logic [COLS-1:0] a_hits = '0, b_hits = '0;
  logic [ROW_W-1:0] a_row = '0, b_row = '0;
  logic a_busy, a_ser, a_ovf, b_busy, b_ser, b_ovf;

  hitser_top #(.COLS(COLS), .ROW_W(ROW_W), .FIFO_DEPTH(16), .PROC_DIV(D)) u_hitser_top (
    .clk(clk), .rst(rst), .row_valid(a_valid), .row_hits(a_hits), .row_num(a_row),
    .busy(a_busy), .ser_out(a_ser), .overflow(a_ovf));

  hitser_top #(.COLS(COLS), .ROW_W(ROW_W), .FIFO_DEPTH(2), .PROC_DIV(1)) u_hitser_top_ovf (
    .clk(clk), .rst(rst), .row_valid(b_valid), .row_hits(b_hits), .row_num(b_row),
    .busy(b_busy), .ser_out(b_ser), .overflow(b_ovf));

  int errors = 0, checks = 0, cyc = 0;
  logic [WW-1:0] expq[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // frame decoder, main instance (R5, R6)
  bit a_in = 0; int a_nb = 0; logic [WW-1:0] a_sh = '0;
  always @(negedge clk) begin
    if (rst) a_in = 0;
    else if (!a_in) begin
      if (a_ser) begin a_in = 1; a_nb = 0; a_sh = '0; end
    end else begin
      a_sh = {a_sh[WW-2:0], a_ser};
      a_nb++;
      if (a_nb == WW) begin
        a_in = 0;
        if (expq.size() == 0) check(0, "R4/R5 unexpected word", a_sh, -1);
        else begin
          logic [WW-1:0] e;
          e = expq.pop_front();
          check(a_sh == e, "R5/R6 frame word", a_sh, e);
        end
      end
    end
  end

  // frame decoder, overflow instance (R8)
  bit b_in = 0; int b_nb = 0, b_frames = 0, b_last = -1; logic [WW-1:0] b_sh = '0;
  always @(negedge clk) begin
    if (rst) begin b_in = 0; b_frames = 0; b_last = -1; end
    else if (!b_in) begin
      if (b_ser) begin b_in = 1; b_nb = 0; b_sh = '0; end
    end else begin
      b_sh = {b_sh[WW-2:0], b_ser};
      b_nb++;
      if (b_nb == WW) begin
        b_in = 0;
        b_frames++;
        check(b_sh[WW-1:COL_W] == 4'd5, "R8 kept word row", b_sh[WW-1:COL_W], 5);
        check(int'(b_sh[COL_W-1:0]) > b_last, "R8 kept words ascend", b_sh[COL_W-1:0], b_last + 1);
        b_last = int'(b_sh[COL_W-1:0]);
      end
    end
  end

  bit done = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog R1..all actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(a_ser == 0 && a_busy == 0 && a_ovf == 0, "R1 reset state main", {a_ser, a_busy, a_ovf}, 0);
    check(b_ser == 0 && b_busy == 0 && b_ovf == 0, "R1 reset state ovf", {b_ser, b_busy, b_ovf}, 0);

    // R8: full row at one column per clock into a 2-entry FIFO
    b_hits = 8'hFF; b_row = 4'd5; b_valid = 1'b1;
    @(negedge clk); b_valid = 1'b0;
    repeat (120) @(negedge clk);
    check(b_ovf == 1, "R8 overflow set", b_ovf, 1);
    check(b_frames == 3, "R8 words kept (FIFO depth plus one in flight)", b_frames, 3);
    repeat (20) @(negedge clk);
    check(b_ovf == 1, "R8 overflow sticky", b_ovf, 1);
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(b_ovf == 0 && b_ser == 0, "R1 reset clears overflow", b_ovf, 0);

    // exhaustive sweep of hit patterns on the main instance
    for (int p = 0; p < 256; p++) begin
      int hi, bcnt;
      bit inj;
      hi = -1;
      a_hits = p[7:0]; a_row = p[3:0]; a_valid = 1'b1;
      for (int c = 0; c < COLS; c++)
        if (p[c]) begin expq.push_back({p[3:0], c[2:0]}); hi = c; end
      @(negedge clk); a_valid = 1'b0;
      if (p == 0) begin
        for (int k = 0; k < 3; k++) begin
          check(a_busy == 0, "R2 empty row leaves busy low", a_busy, 0);
          @(negedge clk);
        end
      end else begin
        check(a_busy == 1, "R3 busy after capture", a_busy, 1);
        inj = (p % 5 == 1);
        bcnt = 0;
        while (a_busy) begin
          bcnt++;
          if (inj && bcnt == 2) begin
            a_valid = 1'b1; a_hits = 8'hFF; a_row = 4'd15;  // R4 ignored row
          end else a_valid = 1'b0;
          @(negedge clk);
          if (bcnt > 200) break;
        end
        a_valid = 1'b0;
        check(bcnt >= (hi + 1) * D + 1 && bcnt <= (hi + 2) * D, "R7 busy length",
              bcnt, (hi + 2) * D);
      end
      repeat (70) @(negedge clk);
      check(expq.size() == 0, "R5 all words delivered", expq.size(), 0);
    end
    check(a_ovf == 0, "R8 no overflow when FIFO keeps up", a_ovf, 0);
    check(a_ser == 0, "R6 line idle at end", a_ser, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule